// File: doc/BRIEF.md
# Watchdog Fault Output with Margin Override

This block drives an active-low watchdog-fault pin that is separate from the main system reset. It combines two kinds of fault. A rail fault is shown at once while any supply rail is flagged under its threshold. A watchdog fault is latched when the host stops toggling its heartbeat input for a set number of clock cycles while every rail is good. The latched watchdog fault is released by a valid heartbeat edge or by pulling the manual reset low. A margin input, when driven low, forces the pin to its inactive level so that supply margining does not raise spurious faults.

Watchdog counting starts only once the main reset block reports that its reset-timeout period has run out, and it stays stopped while manual reset is low. No startup grace window is given: the first timeout is the same length as every later one. A strap input models an unconnected heartbeat pin; when the strap is low, no watchdog timeout can occur. The heartbeat input is asynchronous and passes through a synchronizer. The rail flags, strap, manual reset, timeout-done and margin inputs are taken as synchronous to the clock.

Top module: `wdo_supervisor`

## Requirements
- R1: While `rst_n` is low, and in the first cycles after it rises with all rails good and `margin_n` high, `wdo_n` is 1 (no fault latched).
- R2: With `margin_n` high, `wdo_n` is 0 in the same cycle that any bit of `rail_uv` is 1 (1 means that rail is below its threshold), and it stays 0 while any such bit remains 1.
- R3: When all `rail_uv` bits return to 0, the rail part of `wdo_n` releases in the same cycle with no delay. The timer and the latched watchdog fault are held cleared while any rail is faulted, so no stale timeout appears after recovery.
- R4: With all rails good, `wd_en`, `mr_n` and `rst_tmo_done` all 1, and no edge on `wd_in`, the watchdog fault latches after `TIMEOUT_CYC` clock cycles of counting, and `wdo_n` goes to 0 and stays there.
- R5: A rising or falling edge on `wd_in` releases a latched watchdog fault within `SYNC_STAGES`+1 clock edges.
- R6: `mr_n` low releases a latched watchdog fault at the next clock edge and holds the timer cleared.
- R7: Every rising or falling edge on `wd_in` restarts the timer, so a heartbeat with a period shorter than the timeout keeps `wdo_n` at 1.
- R8: The timer counts only while `rst_tmo_done` is 1 and `mr_n` is 1. With `rst_tmo_done` at 0, no timeout occurs however long `wd_in` stays idle.
- R9: `margin_n` low forces `wdo_n` to 1. The latched state underneath is unchanged and shows again when `margin_n` returns high.
- R10: `wd_en` at 0 stops all watchdog timeouts and releases a latched watchdog fault at the next clock edge.
- R11: Priority is fixed: margin override first, then rail fault, then latched watchdog fault.
- R12: No startup window is applied. The first timeout after arming is `TIMEOUT_CYC` cycles, the same as every later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rail_uv | input | N_RAILS | Per-rail under-voltage flags, 1 = below threshold |
| wd_in | input | 1 | Asynchronous heartbeat input |
| wd_en | input | 1 | Strap, 0 = heartbeat pin left open, watchdog disabled |
| mr_n | input | 1 | Active-low manual reset |
| rst_tmo_done | input | 1 | 1 once the main reset-timeout period has elapsed |
| margin_n | input | 1 | Active-low margin override, forces `wdo_n` high |
| wdo_n | output | 1 | Active-low watchdog-fault output |

## Verification
The bench checks that a rail fault lasting past the timeout does not leave a stale timeout behind on recovery. A design that kept counting under the fault would pull `wdo_n` low within a few cycles of the rails coming back. It holds the heartbeat idle with the reset-timeout indication low and with the strap low, where a timer that ignored its arming conditions would raise a fault. It checks the margin override both over a rail fault and over a latched timeout, then checks that the latched timeout comes back afterwards, which a design that let margin clear the latch would fail to do. It also checks that the first timeout arrives on the normal schedule and is not delayed by a startup window.

// File: rtl/wdo_pkg.sv
package wdo_pkg;

  // Reason the output is at its current level, in priority order
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_WDOG   = 2'd1,
    CAUSE_RAIL   = 2'd2,
    CAUSE_MARGIN = 2'd3
  } wdo_cause_e;

  function automatic logic cause_drives_low(input wdo_cause_e c);
    return (c == CAUSE_RAIL) || (c == CAUSE_WDOG);
  endfunction

endpackage

// File: rtl/wdo_edge_sync.sv
module wdo_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic edge_o
);

  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], d_in};
  end

  for (genvar i = 0; i <= LAST; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= chain_d[i];
    end
  end

  // Any change between the last two stages is a valid transition
  assign edge_o = chain_q[LAST] ^ chain_q[LAST-1];

endmodule

// File: rtl/wdo_timer.sv
module wdo_timer #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rails_bad,
  input  logic wd_edge,
  input  logic wd_en,
  input  logic mr_n,
  input  logic tmo_done,
  output logic fault_o
);

  localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             fault_q, fault_d;
  logic             fault_en;
  logic             armed, run, hit, release_w;

  always_comb begin
    release_w = rails_bad | ~mr_n | ~wd_en | wd_edge;
    armed     = mr_n & tmo_done & wd_en & ~rails_bad;
    run       = armed & ~wd_edge & ~fault_q;
    hit       = run & (cnt_q == CNT_LAST);

    cnt_en = run | (cnt_q != '0);
    cnt_d  = (run && !hit) ? cnt_q + 1'b1 : '0;

    fault_en = release_w | hit;
    fault_d  = release_w ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else if (fault_en) begin
      fault_q <= fault_d;
    end
  end

  assign fault_o = fault_q;

endmodule

// File: rtl/wdo_out_sel.sv
module wdo_out_sel
  import wdo_pkg::*;
(
  input  logic margin_n,
  input  logic rails_bad,
  input  logic wd_fault,
  output logic wdo_n
);

  wdo_cause_e cause;

  always_comb begin
    if (!margin_n)      cause = CAUSE_MARGIN;
    else if (rails_bad) cause = CAUSE_RAIL;
    else if (wd_fault)  cause = CAUSE_WDOG;
    else                cause = CAUSE_NONE;
    wdo_n = ~cause_drives_low(cause);
  end

endmodule

// File: rtl/wdo_supervisor.sv
module wdo_supervisor #(
  parameter int N_RAILS     = 4,
  parameter int TIMEOUT_CYC = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RAILS-1:0] rail_uv,
  input  logic               wd_in,
  input  logic               wd_en,
  input  logic               mr_n,
  input  logic               rst_tmo_done,
  input  logic               margin_n,
  output logic               wdo_n
);

  logic rails_bad;
  logic wd_edge;
  logic wd_fault;

  assign rails_bad = |rail_uv;

  wdo_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   (wd_in),
    .edge_o (wd_edge)
  );

  wdo_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rails_bad (rails_bad),
    .wd_edge   (wd_edge),
    .wd_en     (wd_en),
    .mr_n      (mr_n),
    .tmo_done  (rst_tmo_done),
    .fault_o   (wd_fault)
  );

  wdo_out_sel u_sel (
    .margin_n  (margin_n),
    .rails_bad (rails_bad),
    .wd_fault  (wd_fault),
    .wdo_n     (wdo_n)
  );

endmodule

// File: rtl/wdo_supervisor_chk.sv
module wdo_supervisor_chk #(
  parameter int N_RAILS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_RAILS-1:0] rail_uv,
  input logic               wd_en,
  input logic               mr_n,
  input logic               rst_tmo_done,
  input logic               margin_n,
  input logic               wdo_n,
  input logic               wd_fault
);

  // R9
  margin_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !margin_n |-> wdo_n);

  // R2
  rail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (margin_n && (|rail_uv)) |-> !wdo_n);

  // R3
  rail_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (margin_n && $past(|rail_uv) && !(|rail_uv)) |-> wdo_n);

  // R6
  mr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mr_n |=> !wd_fault);

  // R10
  strap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> !wd_fault);

  // R8
  arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_fault) |-> $past(mr_n && rst_tmo_done && wd_en && !(|rail_uv)));

endmodule

bind wdo_supervisor wdo_supervisor_chk #(.N_RAILS(N_RAILS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rail_uv      (rail_uv),
  .wd_en        (wd_en),
  .mr_n         (mr_n),
  .rst_tmo_done (rst_tmo_done),
  .margin_n     (margin_n),
  .wdo_n        (wdo_n),
  .wd_fault     (wd_fault)
);

// File: tb/wdo_supervisor_test.sv
`timescale 1ns/1ps
module wdo_supervisor_test;

  localparam int NR  = 4;
  localparam int TMO = 64;
  localparam int SYN = 2;

  logic          clk;
  logic          rst_n;
  logic [NR-1:0] rail_uv;
  logic          wd_in, wd_en, mr_n, rst_tmo_done, margin_n;
  logic          wdo_n;

  int n_tests = 0;
  int n_fail  = 0;

  wdo_supervisor #(.N_RAILS(NR), .TIMEOUT_CYC(TMO), .SYNC_STAGES(SYN)) uut (
    .clk(clk), .rst_n(rst_n), .rail_uv(rail_uv), .wd_in(wd_in),
    .wd_en(wd_en), .mr_n(mr_n), .rst_tmo_done(rst_tmo_done),
    .margin_n(margin_n), .wdo_n(wdo_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic          m;
    logic [NR-1:0] r;
    logic          en;
    logic          mr;
    logic          d;
    logic [7:0]    hold;
    logic          exp;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'b0000, 1'b1, 1'b1, 1'b0, 8'd100, 1'b1, 8'd8 },  // R8 not armed
    '{1'b1, 4'b0000, 1'b1, 1'b1, 1'b1, 8'd60,  1'b1, 8'd4 },  // R4 before expiry
    '{1'b1, 4'b0000, 1'b1, 1'b1, 1'b1, 8'd10,  1'b0, 8'd12},  // R12 first timeout on time
    '{1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 8'd1,   1'b1, 8'd9 },  // R9 override
    '{1'b1, 4'b0000, 1'b1, 1'b1, 1'b1, 8'd1,   1'b0, 8'd9 },  // R9 latch kept
    '{1'b1, 4'b0001, 1'b1, 1'b1, 1'b1, 8'd1,   1'b0, 8'd2 },  // R2
    '{1'b1, 4'b0000, 1'b1, 1'b1, 1'b1, 8'd1,   1'b1, 8'd3 },  // R3 immediate release
    '{1'b0, 4'b1000, 1'b1, 1'b1, 1'b1, 8'd1,   1'b1, 8'd11},  // R11 margin over rail
    '{1'b1, 4'b0000, 1'b1, 1'b1, 1'b1, 8'd40,  1'b1, 8'd3 },  // R3
    '{1'b1, 4'b0000, 1'b0, 1'b1, 1'b1, 8'd100, 1'b1, 8'd10},  // R10 strap off
    '{1'b1, 4'b0000, 1'b1, 1'b1, 1'b1, 8'd60,  1'b1, 8'd4 },  // R4
    '{1'b1, 4'b0000, 1'b1, 1'b1, 1'b1, 8'd10,  1'b0, 8'd4 },  // R4 expiry
    '{1'b1, 4'b0000, 1'b1, 1'b0, 1'b1, 8'd1,   1'b1, 8'd6 },  // R6 manual reset
    '{1'b1, 4'b0000, 1'b1, 1'b1, 1'b0, 8'd100, 1'b1, 8'd8 },  // R8 waiting for timeout-done
    '{1'b1, 4'b0000, 1'b1, 1'b1, 1'b1, 8'd60,  1'b1, 8'd8 },  // R8 armed
    '{1'b1, 4'b0000, 1'b1, 1'b1, 1'b1, 8'd10,  1'b0, 8'd4 },  // R4
    '{1'b1, 4'b0000, 1'b0, 1'b1, 1'b1, 8'd1,   1'b1, 8'd10},  // R10 releases latch
    '{1'b1, 4'b0100, 1'b1, 1'b1, 1'b1, 8'd3,   1'b0, 8'd11},  // R11 rail with no latch
    '{1'b1, 4'b0000, 1'b1, 1'b1, 1'b1, 8'd1,   1'b1, 8'd2 }   // R2 release
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic exp, input string tag);
    n_tests++;
    if (wdo_n !== exp) begin
      n_fail++;
      $display("FAIL %s: wdo_n=%b expected %b", tag, wdo_n, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rail_uv = '0; wd_in = 1'b0; wd_en = 1'b1;
    mr_n = 1'b1; rst_tmo_done = 1'b0; margin_n = 1'b1;
    step(3);
    check(1'b1, "R1 in reset");
    rst_n = 1'b1;
    step(2);
    check(1'b1, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      margin_n = VECS[i].m; rail_uv = VECS[i].r; wd_en = VECS[i].en;
      mr_n = VECS[i].mr; rst_tmo_done = VECS[i].d;
      step(int'(VECS[i].hold));
      check(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R5: heartbeat edge releases a timeout
    step(70);
    check(1'b0, "R5 timeout latched");
    wd_in = ~wd_in;
    step(SYN + 2);
    check(1'b1, "R5 released by edge");

    // R7: steady heartbeat keeps the output high
    for (int k = 0; k < 10; k++) begin
      wd_in = ~wd_in;
      step(40);
      check(1'b1, "R7 heartbeat");
    end

    // R3: timer restarts after a rail fault, no stale timeout
    wd_in = ~wd_in;
    step(55);
    check(1'b1, "R3 near expiry");
    rail_uv = 4'b0010;
    step(5);
    check(1'b0, "R2 rail fault");
    rail_uv = '0;
    step(20);
    check(1'b1, "R3 no stale timeout");
    step(50);
    check(1'b0, "R3 fresh timeout");

    // R1: reset mid-run clears the latch
    rst_n = 1'b0;
    #1;
    check(1'b1, "R1 async reset");
    step(2);
    rst_n = 1'b1;
    step(2);
    check(1'b1, "R1 released");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule